// File: doc/BRIEF.md
# Brown-out Fault Qualifier

This controller decides whether a dip in the rectified mains is a genuine brown-out or only a brief interruption that the supply should ride through. It watches one comparator flag, high while the sensed line average sits under a 1 V reference. When that flag rises during normal running, the controller clamps the sense node near the reference and starts a blanking period in which nothing can be declared a fault. A qualification window of the same length follows. The flag being high when blanking ends, or at any point during the window, makes the dip a brown-out.

A declared brown-out shuts the power stage down and keeps it down. The controller disables the gate drivers, resets the soft-start, pulls power-good low and releases the clamp, all on one clock edge. It also turns on the pull-down current that provides threshold hysteresis. The fault stays latched until the line comes back. Timer lengths are counted in clock ticks through a parameter, so a 50 ms nominal period maps onto any system clock.

Top module: `line_dropout_qualifier`

## Requirements
- R1: While `rst` is high, every output is low on the following edge. After release, power-good rises on the first edge at which the synchronized line flag reads low. With `line_low_i` held low across the release, this is the third rising edge after release. With it held high, power-good stays low and no fault is raised.
- R2: `line_low_i` passes through a two-flop synchronizer. From normal running, a rising input shows on the outputs at the third rising edge after the input changes, and not before.
- R3: When the synchronized flag rises during normal running, `clamp_en_o` goes high. Power-good stays high for as long as the clamp is held, through both blanking and the window.
- R4: Blanking lasts `PERIOD_TICKS` cycles. Flag activity inside blanking that has ended before blanking ends never raises a fault.
- R5: If the synchronized flag is high on the last blanking cycle, the fault is declared on the edge that ends blanking, so the clamp has been high for exactly `PERIOD_TICKS` cycles.
- R6: The qualification window lasts `PERIOD_TICKS` cycles. The flag reading high on any window cycle declares the fault on the following edge.
- R7: If the flag stays low for the whole window, the controller returns to normal running with no fault. The clamp is released after exactly 2×`PERIOD_TICKS` cycles, and power-good never drops.
- R8: On the edge a fault is declared, all of the following happen together: `fault_o`, `drv_off_o`, `softstart_rst_o` and `hyst_en_o` go high, and `pgood_o` and `clamp_en_o` go low.
- R9: The fault stays latched while the flag stays high. On the edge the synchronized flag reads low, `fault_o`, `drv_off_o`, `softstart_rst_o` and `hyst_en_o` all drop. `pgood_o` rises one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_low_i | input | 1 | Comparator flag, high when the sensed line is under the reference (asynchronous) |
| clamp_en_o | output | 1 | Enables the source that holds the sense node near the reference |
| fault_o | output | 1 | Latched brown-out fault |
| pgood_o | output | 1 | Power-good for the downstream converter |
| drv_off_o | output | 1 | Forces the gate drivers off |
| softstart_rst_o | output | 1 | Grounds the control node so restart ramps up softly |
| hyst_en_o | output | 1 | Enables the hysteresis pull-down current on the sense pin |

## Verification
The bench measures how many cycles the clamp stays high.

- A dip that clears during blanking must give exactly two periods. A design with a wrong timer length or an off-by-one expiry test changes that count.
- A dip that persists must give exactly one period. A design that ignored the flag at the end of blanking would run on into the window.
- A second glitch inside blanking must not fault. A design that faulted during blanking, or that restarted the timer on every edge, would fail this case.
- A rise late in the window must fault at a precise cycle, one edge after the synchronized flag is seen.

The recovery sequence is checked edge by edge: the fault and driver controls drop together, and power-good rises one edge later. A design that released power-good early, or left the drivers disabled for an extra cycle, would fail this check. The bench also probes the synchronizer latency and holding reset with a low line.

// File: rtl/lq_pkg.sv
package lq_pkg;

  typedef enum logic [2:0] {
    ST_INIT   = 3'd0,
    ST_NORMAL = 3'd1,
    ST_BLANK  = 3'd2,
    ST_WINDOW = 3'd3,
    ST_FAULT  = 3'd4
  } lq_state_e;

  typedef struct packed {
    logic clamp;
    logic fault;
    logic pgood;
    logic drv_off;
    logic ss_rst;
    logic hyst;
  } lq_out_t;

  // Output image of each state; registered by the controller.
  function automatic lq_out_t lq_decode(lq_state_e s);
    lq_out_t o;
    o = '0;
    case (s)
      ST_NORMAL: o.pgood = 1'b1;
      ST_BLANK,
      ST_WINDOW: begin
        o.clamp = 1'b1;
        o.pgood = 1'b1;
      end
      ST_FAULT: begin
        o.fault   = 1'b1;
        o.drv_off = 1'b1;
        o.ss_rst  = 1'b1;
        o.hyst    = 1'b1;
      end
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lq_sync.sv
module lq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/lq_timer.sv
module lq_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);

  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + W'(1);
  end

  assign expired = (cnt == LAST);

endmodule

// File: rtl/lq_ctrl.sv
module lq_ctrl
  import lq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    low_s,
  input  logic    expired,
  output logic    tmr_clear,
  output lq_out_t outs
);

  lq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_INIT:   if (!low_s) state_d = ST_NORMAL;
      ST_NORMAL: if (low_s)  state_d = ST_BLANK;
      ST_BLANK:  if (expired) state_d = low_s ? ST_FAULT : ST_WINDOW;
      ST_WINDOW: begin
        if (low_s)        state_d = ST_FAULT;
        else if (expired) state_d = ST_NORMAL;
      end
      ST_FAULT:  if (!low_s) state_d = ST_INIT;
      default:   state_d = ST_INIT;
    endcase
  end

  // Restart the timer on every state change so each period starts at zero.
  assign tmr_clear = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      outs    <= '0;
    end else begin
      state_q <= state_d;
      outs    <= lq_decode(state_d);
    end
  end

endmodule

// File: rtl/line_dropout_qualifier.sv
module line_dropout_qualifier #(
  parameter int unsigned PERIOD_TICKS = 6_250_000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_low_i,
  output logic clamp_en_o,
  output logic fault_o,
  output logic pgood_o,
  output logic drv_off_o,
  output logic softstart_rst_o,
  output logic hyst_en_o
);

  import lq_pkg::*;

  logic    low_s;
  logic    expired;
  logic    tmr_clear;
  lq_out_t outs;

  // Reset to "line low" so power-good waits for a real reading.
  lq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_low_i),
    .q   (low_s)
  );

  lq_timer #(.LIMIT(PERIOD_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .expired (expired)
  );

  lq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .low_s     (low_s),
    .expired   (expired),
    .tmr_clear (tmr_clear),
    .outs      (outs)
  );

  assign clamp_en_o      = outs.clamp;
  assign fault_o         = outs.fault;
  assign pgood_o         = outs.pgood;
  assign drv_off_o       = outs.drv_off;
  assign softstart_rst_o = outs.ss_rst;
  assign hyst_en_o       = outs.hyst;

endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
  parameter int unsigned PERIOD_TICKS = 8
) (
  input logic clk,
  input logic rst,
  input logic clamp_en_o,
  input logic fault_o,
  input logic pgood_o,
  input logic drv_off_o,
  input logic softstart_rst_o,
  input logic hyst_en_o
);

  localparam int unsigned CAP = 2 * PERIOD_TICKS + 1;
  localparam int unsigned RW  = $clog2(CAP + 1);

  // Consecutive cycles with the clamp held, saturating just past the legal maximum.
  logic [RW-1:0] clamp_run;

  always_ff @(posedge clk) begin
    if (rst || !clamp_en_o)            clamp_run <= '0;
    else if (clamp_run != RW'(CAP))    clamp_run <= clamp_run + RW'(1);
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pgood_o && !fault_o && !clamp_en_o && !drv_off_o && !softstart_rst_o && !hyst_en_o));

  a_r3_pgood_while_clamped: assert property (@(posedge clk) disable iff (rst)
    clamp_en_o |-> pgood_o);

  a_r5_no_fault_in_blanking: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> (int'(clamp_run) >= int'(PERIOD_TICKS)));

  a_r6_fault_within_window: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> (int'(clamp_run) <= int'(2 * PERIOD_TICKS)));

  a_r7_clamp_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(clamp_run) <= int'(2 * PERIOD_TICKS));

  a_r8_fault_actions: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!pgood_o && !clamp_en_o && drv_off_o && softstart_rst_o && hyst_en_o));

  a_r9_clear_together: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> (!drv_off_o && !softstart_rst_o && !hyst_en_o && !pgood_o));

  a_r9_pgood_late: assert property (@(posedge clk) disable iff (rst)
    $past(fault_o) |-> !pgood_o);

endmodule

bind line_dropout_qualifier lq_checker #(.PERIOD_TICKS(PERIOD_TICKS)) u_lq_checker (
  .clk             (clk),
  .rst             (rst),
  .clamp_en_o      (clamp_en_o),
  .fault_o         (fault_o),
  .pgood_o         (pgood_o),
  .drv_off_o       (drv_off_o),
  .softstart_rst_o (softstart_rst_o),
  .hyst_en_o       (hyst_en_o)
);

// File: tb/tb_line_dropout_qualifier.sv
`timescale 1ns/1ps
module tb_line_dropout_qualifier;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_low_i = 1'b0;
  logic clamp_en_o, fault_o, pgood_o, drv_off_o, softstart_rst_o, hyst_en_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  line_dropout_qualifier #(.PERIOD_TICKS(N)) dut (
    .clk             (clk),
    .rst             (rst),
    .line_low_i      (line_low_i),
    .clamp_en_o      (clamp_en_o),
    .fault_o         (fault_o),
    .pgood_o         (pgood_o),
    .drv_off_o       (drv_off_o),
    .softstart_rst_o (softstart_rst_o),
    .hyst_en_o       (hyst_en_o)
  );

  always @(posedge clk) cycles <= cycles + 1;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Step while the clamp is high; returns the number of clamp-high samples (first one included).
  task automatic clamp_run(input int already, output int n, output int pg_drops, output int faults);
    n = already; pg_drops = 0; faults = 0;
    while (clamp_en_o && n < 100) begin
      if (!pgood_o) pg_drops++;
      if (fault_o) faults++;
      step();
      if (clamp_en_o) n++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; line_low_i = 1'b0;
    step(); step();
    rst = 1'b0;
    step(); step(); step();
  endtask

  task automatic t_reset();
    rst = 1'b1; line_low_i = 1'b1;
    step(); step();
    chk("R1", "pgood in reset", pgood_o, 0);
    chk("R1", "fault in reset", fault_o, 0);
    chk("R1", "clamp in reset", clamp_en_o, 0);
    chk("R1", "drivers off in reset", drv_off_o, 0);
    rst = 1'b0;
    repeat (6) step();
    chk("R1", "pgood with line low after reset", pgood_o, 0);
    chk("R1", "no fault with line low after reset", fault_o, 0);
    rst = 1'b1; line_low_i = 1'b0;
    step();
    rst = 1'b0;
    step(); step();
    chk("R1", "pgood two edges after release", pgood_o, 0);
    step();
    chk("R1", "pgood three edges after release", pgood_o, 1);
  endtask

  task automatic t_short_dip();
    int n, pg, fl;
    line_low_i = 1'b1;
    step(); step();
    chk("R2", "clamp before third edge", clamp_en_o, 0);
    line_low_i = 1'b0;
    step();
    chk("R2", "clamp at third edge", clamp_en_o, 1);
    chk("R3", "pgood at clamp start", pgood_o, 1);
    clamp_run(1, n, pg, fl);
    chk("R7", "clamp length for recovered dip", n, 2 * N);
    chk("R3", "pgood drops while clamped", pg, 0);
    chk("R7", "faults during recovered dip", fl, 0);
    chk("R7", "pgood after window", pgood_o, 1);
    chk("R7", "fault after window", fault_o, 0);
  endtask

  task automatic t_blank_glitch();
    int n, pg, fl;
    line_low_i = 1'b1;
    step(); step();
    line_low_i = 1'b0;
    step();
    chk("R4", "clamp started", clamp_en_o, 1);
    line_low_i = 1'b1;
    step(); step();
    line_low_i = 1'b0;
    clamp_run(3, n, pg, fl);
    chk("R4", "faults from glitch in blanking", fl, 0);
    chk("R4", "clamp length with glitch in blanking", n, 2 * N);
    chk("R4", "fault after glitch case", fault_o, 0);
  endtask

  task automatic t_fault_end_blank();
    int n, pg, fl;
    line_low_i = 1'b1;
    step(); step(); step();
    chk("R5", "clamp started", clamp_en_o, 1);
    clamp_run(1, n, pg, fl);
    chk("R5", "clamp length before fault", n, N);
    chk("R5", "fault at blanking end", fault_o, 1);
    chk("R8", "pgood on fault", pgood_o, 0);
    chk("R8", "drivers off on fault", drv_off_o, 1);
    chk("R8", "softstart reset on fault", softstart_rst_o, 1);
    chk("R8", "hysteresis on fault", hyst_en_o, 1);
    chk("R8", "clamp on fault", clamp_en_o, 0);
    repeat (20) step();
    chk("R9", "fault latched while line low", fault_o, 1);
    line_low_i = 1'b0;
    step(); step();
    chk("R9", "fault before sync delay", fault_o, 1);
    step();
    chk("R9", "fault cleared", fault_o, 0);
    chk("R9", "drivers released", drv_off_o, 0);
    chk("R9", "softstart released", softstart_rst_o, 0);
    chk("R9", "hysteresis released", hyst_en_o, 0);
    chk("R9", "pgood still low at clear", pgood_o, 0);
    step();
    chk("R9", "pgood one edge after clear", pgood_o, 1);
  endtask

  task automatic t_fault_in_window();
    int n, pg, fl;
    line_low_i = 1'b1;
    step(); step();
    line_low_i = 1'b0;
    step();
    chk("R6", "clamp started", clamp_en_o, 1);
    repeat (N + 2) step();
    chk("R6", "still clamped in window", clamp_en_o, 1);
    line_low_i = 1'b1;
    clamp_run(N + 3, n, pg, fl);
    chk("R6", "clamp length with window fault", n, N + 5);
    chk("R6", "fault declared in window", fault_o, 1);
    chk("R8", "pgood low on window fault", pgood_o, 0);
    line_low_i = 1'b0;
    repeat (5) step();
    chk("R9", "recovered after window fault", pgood_o, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        do_reset();
        t_short_dip();
        repeat (4) step();
        t_blank_glitch();
        repeat (4) step();
        t_fault_end_blank();
        repeat (4) step();
        t_fault_in_window();
      end
      begin
        wait (cycles > 20000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule